// File: doc/BRIEF.md
# Indexed Colour Palette Register Interface

This block holds a 256-entry colour lookup table, each entry made of three 8-bit components kept as red, green and blue. A host reaches it through four 32-bit word registers. Every colour byte and every index travels in bits 31:24 of the bus word; the lower 24 bits are ignored on writes and read back as zero. The host first loads a start index into the address register. After that, each access to the palette data port touches one component of the current entry, stepping red, green, blue, and then moves to the next entry. So a burst of 768 accesses from index 0 covers the whole table.

Four small control registers sit behind one control port. The address register value picks which of them is reached: 4 is the pixel read mask, 5 the blink mask, 6 the command register and 7 the test register. A second, smaller overlay colour table uses the same component stepping through its own port. On the display side, an 8-bit pixel index is ANDed with the read mask and turned into a 24-bit RGB word one clock later.

Top module: `clut_regs`

## Requirements
- R1: After reset the entry index is 0 and the component phase is red. The read mask is 0xFF, and the blink mask, command and test registers are 0x00.
- R2: Word 0 (address register) writes load the entry index from bits 31:24 and return the phase to red. Reads of word 0 return the index in bits 31:24 with zero below, and do not move the index or the phase.
- R3: Each write to word 1 (palette data) stores bits 31:24 into the current component of the current entry. The component then steps red to green to blue, and after blue the phase returns to red and the index increments.
- R4: Each read of word 1 returns the current component in bits 31:24 with bits 23:0 zero, and steps the phase and index exactly as a write does.
- R5: Incrementing past index 255 wraps the index to 0.
- R6: Word 2 (control port) reaches the register picked by the index: 4 read mask, 5 blink mask, 6 command, 7 test. Any other index ignores writes and reads 0. A control access never moves the index or the phase.
- R7: Output ovl_en carries bits 1:0 of the command register, so a write of 0x70 leaves it 0 and a write of 0x73 sets it to 3.
- R8: pix_rgb presents {red, green, blue} of entry (pix_idx AND read mask) on the clock edge after pix_idx is applied, with red in bits 23:16.
- R9: Word 3 (overlay port) accesses an OVL_N-entry overlay table at the index modulo OVL_N. It uses the same component stepping and index increment as word 1, and leaves the palette untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_off | input | 2 | Word select: 0 address, 1 palette data, 2 control, 3 overlay |
| bus_wdata | input | 32 | Write data, meaningful bits 31:24 |
| bus_rdata | output | 32 | Read data, combinational, meaningful bits 31:24 |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Registered colour {red, green, blue} |
| ovl_en | output | 2 | Overlay enable bits from the command register |

## Verification
The bench builds the block with its default OVL_N of 4. The full 256-entry table can therefore be filled in one 768-access burst, and the wrap from index 255 to 0 is reached directly. With four overlay entries, indices 1 and 5 alias to the same overlay entry, which shows the modulo mapping. The pixel path is checked under both an all-ones read mask and a narrowed mask, both on the cycle before and on the cycle after the registered update.

// File: rtl/clut_regs.sv
module clut_regs #(
  parameter int OVL_N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_off,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  pix_idx,
  output logic [23:0] pix_rgb,
  output logic [1:0]  ovl_en
);
  localparam int ENTRIES = 256;
  localparam int OVL_W   = (OVL_N > 1) ? $clog2(OVL_N) : 1;

  logic [7:0] idx_q;
  logic [1:0] phase_q;
  logic [7:0] rmask_q, bmask_q, cmd_q, test_q;
  logic [7:0] pal [3][ENTRIES];
  logic [7:0] ovl [3][OVL_N];
  logic [7:0] ctrl_rd;

  wire [7:0] wbyte    = bus_wdata[31:24];
  wire       acc_addr = bus_en && (bus_off == 2'd0);
  wire       acc_data = bus_en && (bus_off == 2'd1);
  wire       acc_ctrl = bus_en && (bus_off == 2'd2);
  wire       acc_ovl  = bus_en && (bus_off == 2'd3);
  wire       step     = acc_data || acc_ovl;
  wire [OVL_W-1:0] oidx = idx_q[OVL_W-1:0];
  wire [7:0] pmask    = pix_idx & rmask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= '0;
    end else if (acc_addr && bus_we) begin
      idx_q   <= wbyte;
      phase_q <= '0;
    end else if (step) begin
      if (phase_q == 2'd2) begin
        phase_q <= '0;
        idx_q   <= idx_q + 8'd1;
      end else begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmask_q <= 8'hFF;
      bmask_q <= 8'h00;
      cmd_q   <= 8'h00;
      test_q  <= 8'h00;
    end else if (acc_ctrl && bus_we) begin
      case (idx_q)
        8'd4: rmask_q <= wbyte;
        8'd5: bmask_q <= wbyte;
        8'd6: cmd_q   <= wbyte;
        8'd7: test_q  <= wbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_data && bus_we) pal[phase_q][idx_q] <= wbyte;
    if (acc_ovl && bus_we)  ovl[phase_q][oidx]  <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= {pal[0][pmask], pal[1][pmask], pal[2][pmask]};
  end

  always_comb begin
    case (idx_q)
      8'd4:    ctrl_rd = rmask_q;
      8'd5:    ctrl_rd = bmask_q;
      8'd6:    ctrl_rd = cmd_q;
      8'd7:    ctrl_rd = test_q;
      default: ctrl_rd = 8'h00;
    endcase
  end

  always_comb begin
    case (bus_off)
      2'd0:    bus_rdata = {idx_q, 24'h0};
      2'd1:    bus_rdata = {pal[phase_q][idx_q], 24'h0};
      2'd2:    bus_rdata = {ctrl_rd, 24'h0};
      default: bus_rdata = {ovl[phase_q][oidx], 24'h0};
    endcase
  end

  assign ovl_en = cmd_q[1:0];
endmodule

// File: rtl/clut_regs_chk.sv
module clut_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [1:0]  bus_off,
  input logic [31:0] bus_wdata,
  input logic [7:0]  idx,
  input logic [1:0]  phase,
  input logic [1:0]  ovl_en
);
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_off == 2'd0) |=> (idx == $past(bus_wdata[31:24]) && phase == 2'd0));

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  assert_entry_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_off[0] && phase == 2'd2) |=> (phase == 2'd0 && idx == $past(idx) + 8'd1));

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_off == 2'd2) |=> ($stable(idx) && $stable(phase)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en) |=> ($stable(idx) && $stable(phase)));

  assert_cursor_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_off == 2'd2 && idx == 8'd6) |=> (ovl_en == $past(bus_wdata[25:24])));
endmodule

bind clut_regs clut_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
  .bus_wdata(bus_wdata), .idx(idx_q), .phase(phase_q), .ovl_en(ovl_en)
);

// File: tb/clut_regs_tb.sv
module clut_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [1:0]  bus_off = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = 0;
  logic [23:0] pix_rgb;
  logic [1:0]  ovl_en;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  m_pal [3][256];
  logic [7:0]  cur_mask = 8'hFF;
  logic [7:0]  pix_cur = 0;

  always #10 clk = ~clk;

  clut_regs #(.OVL_N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .pix_rgb(pix_rgb), .ovl_en(ovl_en)
  );

  task automatic chk(input logic ok, input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      if (exp_q.size() == 0) chk(1'b0, bus_rdata, 32'h0, "scoreboard underflow");
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata === e, bus_rdata, e, t);
      end
    end
  end

  task automatic wr(input logic [1:0] off, input logic [7:0] b);
    @(posedge clk); #2;
    bus_en = 1; bus_we = 1; bus_off = off; bus_wdata = {b, 24'h5A5A5A};
  endtask

  task automatic rd(input logic [1:0] off, input logic [7:0] b, input string tag);
    exp_q.push_back({b, 24'h0});
    tag_q.push_back(tag);
    @(posedge clk); #2;
    bus_en = 1; bus_we = 0; bus_off = off; bus_wdata = 32'hFFFF_FFFF;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    bus_en = 0; bus_we = 0;
  endtask

  function automatic logic [23:0] lookup(input logic [7:0] p);
    logic [7:0] m;
    m = p & cur_mask;
    return {m_pal[0][m], m_pal[1][m], m_pal[2][m]};
  endfunction

  task automatic pix(input logic [7:0] v, input string tag);
    logic [23:0] old;
    @(posedge clk); #2;
    bus_en = 0;
    old = lookup(pix_cur);
    pix_idx = v;
    @(negedge clk);
    chk(pix_rgb === old, {8'h0, pix_rgb}, {8'h0, old}, {tag, " before edge"});
    @(posedge clk); @(negedge clk);
    chk(pix_rgb === lookup(v), {8'h0, pix_rgb}, {8'h0, lookup(v)}, tag);
    pix_cur = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    rd(0, 8'h00, "R1 reset index");
    wr(0, 8'd4); rd(2, 8'hFF, "R1 read mask reset");
    wr(0, 8'd5); rd(2, 8'h00, "R1 blink mask reset");
    wr(0, 8'd6); rd(2, 8'h00, "R1 command reset");
    wr(0, 8'd7); rd(2, 8'h00, "R1 test reset");
    idle(); @(negedge clk);
    chk(ovl_en === 2'd0, {30'h0, ovl_en}, 32'h0, "R1 ovl_en reset");

    wr(0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      for (int c = 0; c < 3; c++) begin
        logic [7:0] v;
        v = (c == 0) ? 8'(i) : (c == 1) ? (8'(i) ^ 8'h5A) : 8'(i * 3 + 7);
        m_pal[c][i] = v;
        wr(1, v);
      end
    end
    rd(0, 8'h00, "R5 index wrapped after 768 writes");

    wr(0, 8'h10);
    for (int i = 16; i < 18; i++)
      for (int c = 0; c < 3; c++) rd(1, m_pal[c][i], "R4 sequential read");
    rd(0, 8'h12, "R4 index advanced by reads");

    wr(0, 8'd3); rd(1, m_pal[0][3], "R2 red first");
    wr(0, 8'd3); rd(1, m_pal[0][3], "R2 phase cleared by address write");
    rd(1, m_pal[1][3], "R2 green next");
    rd(0, 8'd3, "R2 address read mid-entry");
    rd(1, m_pal[2][3], "R2 address read kept phase");

    wr(0, 8'h40); wr(1, 8'd11); wr(1, 8'd22);
    m_pal[0][8'h40] = 8'd11; m_pal[1][8'h40] = 8'd22;
    wr(0, 8'h40);
    rd(1, 8'd11, "R3 red written");
    rd(1, 8'd22, "R3 green written");
    rd(1, m_pal[2][8'h40], "R3 blue untouched by partial write");
    rd(0, 8'h41, "R3 index advanced after blue");

    wr(0, 8'hFF); wr(1, 8'd1); wr(1, 8'd2); wr(1, 8'd3);
    m_pal[0][255] = 1; m_pal[1][255] = 2; m_pal[2][255] = 3;
    rd(0, 8'h00, "R5 wrap 255 to 0");
    wr(1, 8'd9); m_pal[0][0] = 9;
    wr(0, 8'hFF);
    rd(1, 8'd1, "R5 entry 255 red");
    rd(1, 8'd2, "R5 entry 255 green");
    rd(1, 8'd3, "R5 entry 255 blue");
    rd(1, 8'd9, "R5 write after wrap reached entry 0");

    wr(0, 8'd6); wr(2, 8'h70); rd(2, 8'h70, "R6 command readback");
    idle(); @(negedge clk);
    chk(ovl_en === 2'd0, {30'h0, ovl_en}, 32'h0, "R7 0x70 leaves overlay off");
    wr(2, 8'h73);
    idle(); @(negedge clk);
    chk(ovl_en === 2'd3, {30'h0, ovl_en}, 32'h3, "R7 overlay enable bits");
    rd(1, m_pal[0][6], "R6 control access kept index and phase");
    wr(0, 8'd2); wr(2, 8'hEE); rd(2, 8'h00, "R6 unmapped index reads zero");
    wr(0, 8'd4); rd(2, 8'hFF, "R6 unmapped write ignored");
    wr(0, 8'd5); wr(2, 8'hA5); rd(2, 8'hA5, "R6 blink mask");
    wr(0, 8'd7); wr(2, 8'h3C); rd(2, 8'h3C, "R6 test register");
    wr(0, 8'd5); rd(2, 8'hA5, "R6 blink mask kept");
    wr(0, 8'd2); rd(1, m_pal[0][2], "R6 palette untouched by control writes");
    idle();

    pix(8'h37, "R8 lookup full mask");
    pix(8'hC5, "R8 lookup second index");
    wr(0, 8'd4); wr(2, 8'h0F); idle();
    cur_mask = 8'h0F;
    pix(8'h37, "R8 masked lookup");
    pix(8'hFF, "R8 masked top index");

    wr(0, 8'd1); wr(3, 8'h11); wr(3, 8'h22); wr(3, 8'h33);
    rd(0, 8'd2, "R9 overlay writes step index");
    wr(0, 8'd5);
    rd(3, 8'h11, "R9 overlay red by modulo index");
    rd(3, 8'h22, "R9 overlay green");
    rd(3, 8'h33, "R9 overlay blue");
    rd(0, 8'd6, "R9 overlay reads step index");
    wr(0, 8'd1);
    rd(1, m_pal[0][1], "R9 palette red untouched");
    rd(1, m_pal[1][1], "R9 palette green untouched");
    idle(); idle();

    if (exp_q.size() != 0) chk(1'b0, exp_q.size(), 0, "scoreboard leftover");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule